// File: doc/BRIEF.md
# Dual-Thread Trust Scoring and Recovery Controller

This block keeps a saturating trust score for each of two redundant hardware threads that run the same program. It decides how the threads recover when a transient fault is reported. A checkpoint strobe marks the end of a checkpoint interval. A fault strobe, with a thread number beside it, reports a fault in that thread. Intervals that finish clean raise the thread's score by one. The first fault in an interval lowers the score by one. Every later fault in the same interval halves the score. The configured floor and ceiling bound the score at all times.

When a fault comes in, the block compares the faulting thread's score with a threshold. If the score is above the threshold, the block asks for a roll-forward: the leading thread carries on, and the trailing thread re-executes from the last checkpoint. If the score is not above the threshold, the block asks for a rollback of the faulting thread. It also asks for a rollback of every other thread whose score is at or below the threshold. The block does not detect faults, compute checksums or restore state. It only produces the scores and the request pulses.

Top module: `trust_rollback_ctrl`

## Requirements
- R1: While rst_ni is low, the block captures floor, ceiling and threshold from min_i, max_i and thr_i, and every trust score is set to the ceiling. Changing those three pins after reset release has no effect. After reset, no request is active.
- R2: The first fault a thread takes in a checkpoint interval lowers its trust by one. If the trust is already at the floor, it stays at the floor.
- R3: Each further fault on the same thread in the same interval sets its trust to the current value shifted right by one bit. If the result is below the floor, the trust becomes the floor.
- R4: A checkpoint strobe that ends an interval with no fault on a thread raises that thread's trust by one. If the trust is already at the ceiling, it stays at the ceiling.
- R5: A checkpoint strobe that ends an interval in which a thread took a fault leaves that thread's trust unchanged. The next fault on that thread counts as a first fault again.
- R6: When a checkpoint strobe and a fault arrive in the same cycle, the block applies the fault first. That interval counts as faulty, so there is no increment, and the following fault counts as a first fault.
- R7: A fault whose thread had trust strictly greater than the threshold in the fault cycle raises rollfwd_o for exactly the next cycle. In that case no rollback bit is raised.
- R8: A fault whose thread had trust at or below the threshold raises the rollback bit of the faulting thread in the next cycle. In the same cycle it raises the rollback bit of each other thread whose trust is at or below the threshold, and rollfwd_o stays low.
- R9: In the cycle after a cycle with fault_i low, rollback_o and rollfwd_o are all zero.
- R10: A fault on one thread does not change the other thread's trust.
- R11: fault_tid_i = 0 selects the leading thread: trust bits [7:0] and rollback bit 0. The value 1 selects the trailing thread: trust bits [15:8] and rollback bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; configuration is captured while it is low |
| ckpt_i | input | 1 | Checkpoint strobe, ends the current interval |
| fault_i | input | 1 | Fault strobe |
| fault_tid_i | input | 1 | Thread of the fault (0 leading, 1 trailing) |
| min_i | input | 8 | Trust floor |
| max_i | input | 8 | Trust ceiling and reset value |
| thr_i | input | 8 | Roll-forward threshold |
| trust_o | output | 16 | Trust scores, thread 0 in the low byte |
| rollback_o | output | 2 | Per-thread rollback request pulses |
| rollfwd_o | output | 1 | Roll-forward request pulse |

## Verification
Every result is due one clock edge after the strobes that cause it. That edge updates both the trust scores and the request pulses, and the decision uses the trust value held in the strobe cycle. The bench drives strobes on a falling edge and steps the reference model once for each of those cycles. It compares every output on the next falling edge, so each comparison looks at the cycle where the registered result first appears. The bench holds inputs for exactly one edge, so a strobe is never counted twice.

// File: rtl/trc_pkg.sv
package trc_pkg;
  parameter int TRUST_W = 8;
  typedef logic [TRUST_W-1:0] trust_t;
endpackage

// File: rtl/trust_cell.sv
module trust_cell
  import trc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  trust_t rst_val_i,
  input  trust_t min_i,
  input  trust_t max_i,
  input  logic   hit_i,
  input  logic   ckpt_i,
  output trust_t trust_o
);
  trust_t trust_q, after_hit, trust_d, halved;
  logic   seen_q, seen_mid;

  assign halved = trust_q >> 1;

  // fault applied before checkpoint
  always_comb begin
    after_hit = trust_q;
    if (hit_i) begin
      if (seen_q) after_hit = (halved < min_i) ? min_i : halved;
      else        after_hit = (trust_q > min_i) ? trust_q - 1'b1 : min_i;
    end
  end

  assign seen_mid = seen_q | hit_i;

  always_comb begin
    trust_d = after_hit;
    if (ckpt_i && !seen_mid && after_hit < max_i) trust_d = after_hit + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trust_q <= rst_val_i;
      seen_q  <= 1'b0;
    end else begin
      trust_q <= trust_d;
      seen_q  <= ckpt_i ? 1'b0 : seen_mid;
    end
  end

  assign trust_o = trust_q;

  assert_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_i <= max_i) |-> (trust_q >= min_i && trust_q <= max_i));

  assert_first_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !seen_q && trust_q > min_i) |=> (trust_q == $past(trust_q) - 1'b1));

  assert_repeat_halve_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && seen_q && (trust_q >> 1) >= min_i) |=> (trust_q == ($past(trust_q) >> 1)));

  assert_clean_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ckpt_i && !hit_i && !seen_q && trust_q < max_i) |=> (trust_q == $past(trust_q) + 1'b1));

  assert_no_rise_faulty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ckpt_i && seen_q && !hit_i) |=> $stable(trust_q));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ckpt_i && !hit_i) |=> $stable(trust_q));
endmodule

// File: rtl/recovery_decide.sv
module recovery_decide
  import trc_pkg::*;
#(
  parameter int N_THR = 2,
  parameter int TID_W = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fault_i,
  input  logic [TID_W-1:0]         fault_tid_i,
  input  logic [N_THR*TRUST_W-1:0] trust_i,
  input  trust_t                   thr_i,
  output logic [N_THR-1:0]         rollback_o,
  output logic                     rollfwd_o
);
  trust_t           flt_trust;
  logic             trusted;
  logic [N_THR-1:0] rb_d;

  assign flt_trust = trust_i[fault_tid_i*TRUST_W +: TRUST_W];
  assign trusted   = flt_trust > thr_i;

  for (genvar i = 0; i < N_THR; i++) begin : g_rb
    assign rb_d[i] = fault_i && !trusted &&
                     ((fault_tid_i == TID_W'(i)) || (trust_i[i*TRUST_W +: TRUST_W] <= thr_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rollback_o <= '0;
      rollfwd_o  <= 1'b0;
    end else begin
      rollback_o <= rb_d;
      rollfwd_o  <= fault_i && trusted;
    end
  end

  assert_fwd_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollfwd_o |-> (rollback_o == '0));

  assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_i |=> (rollback_o == '0 && !rollfwd_o));

  assert_one_action_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (rollfwd_o != rollback_o[$past(fault_tid_i)]));

  assert_fwd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rollfwd_o && !$past(fault_i, 1)) |-> 1'b0);
endmodule

// File: rtl/trust_rollback_ctrl.sv
module trust_rollback_ctrl
  import trc_pkg::*;
#(
  parameter int N_THR = 2,
  localparam int TID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ckpt_i,
  input  logic                     fault_i,
  input  logic [TID_W-1:0]         fault_tid_i,
  input  logic [TRUST_W-1:0]       min_i,
  input  logic [TRUST_W-1:0]       max_i,
  input  logic [TRUST_W-1:0]       thr_i,
  output logic [N_THR*TRUST_W-1:0] trust_o,
  output logic [N_THR-1:0]         rollback_o,
  output logic                     rollfwd_o
);
  trust_t min_q, max_q, thr_q;

  // configuration is held while reset is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= min_i;
      max_q <= max_i;
      thr_q <= thr_i;
    end
  end

  for (genvar i = 0; i < N_THR; i++) begin : g_thr
    trust_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rst_val_i(max_i),
      .min_i    (min_q),
      .max_i    (max_q),
      .hit_i    (fault_i && (fault_tid_i == TID_W'(i))),
      .ckpt_i   (ckpt_i),
      .trust_o  (trust_o[i*TRUST_W +: TRUST_W])
    );
  end

  recovery_decide #(.N_THR(N_THR), .TID_W(TID_W)) u_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fault_i    (fault_i),
    .fault_tid_i(fault_tid_i),
    .trust_i    (trust_o),
    .thr_i      (thr_q),
    .rollback_o (rollback_o),
    .rollfwd_o  (rollfwd_o)
  );

  assert_cfg_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(min_q) && $stable(max_q) && $stable(thr_q)));
endmodule

// File: tb/trust_rollback_ctrl_bench.sv
`timescale 1ns/1ps
module trust_rollback_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ckpt_i = 1'b0, fault_i = 1'b0;
  logic [0:0]  tid_i = '0;
  logic [7:0]  min_i, max_i, thr_i;
  logic [15:0] trust_o;
  logic [1:0]  rollback_o;
  logic        rollfwd_o;

  int checks = 0, errors = 0, cycles = 0;
  int mt[2];
  bit ms[2];
  int mmin, mmax, mthr;

  always #4 clk = ~clk;

  trust_rollback_ctrl u_trust_rollback_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ckpt_i(ckpt_i), .fault_i(fault_i),
    .fault_tid_i(tid_i), .min_i(min_i), .max_i(max_i), .thr_i(thr_i),
    .trust_o(trust_o), .rollback_o(rollback_o), .rollfwd_o(rollfwd_o));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic int nxt(int t, bit hit, bit s, bit c);
    int v = t;
    if (hit) begin
      if (s) v = ((t >> 1) < mmin) ? mmin : (t >> 1);
      else   v = (t > mmin) ? t - 1 : mmin;
    end
    if (c && !(s || hit)) v = (v < mmax) ? v + 1 : mmax;
    return v;
  endfunction

  task automatic do_reset(int lo, int hi, int th);
    @(negedge clk);
    min_i = 8'(lo); max_i = 8'(hi); thr_i = 8'(th);
    ckpt_i = 0; fault_i = 0; tid_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mmin = lo; mmax = hi; mthr = th;
    for (int i = 0; i < 2; i++) begin mt[i] = hi; ms[i] = 0; end
    // R1: pins changed after release must not matter
    min_i = 8'hA5; max_i = 8'h07; thr_i = 8'h00;
    @(negedge clk);
    chk("R1 trust0 reset", trust_o[7:0], hi);
    chk("R1 trust1 reset", trust_o[15:8], hi);
    chk("R1 rollback reset", rollback_o, 0);
    chk("R1 rollfwd reset", rollfwd_o, 0);
  endtask

  // called on a falling edge; checks on the next one
  task automatic step(bit c, bit f, bit t);
    int et[2]; bit es[2]; int erb = 0; bit erf = 0;
    string rt[2]; string rr;
    ckpt_i = c; fault_i = f; tid_i = t;
    if (f) begin
      if (mt[t] > mthr) erf = 1;
      else for (int i = 0; i < 2; i++)
        if (i == int'(t) || mt[i] <= mthr) erb |= (1 << i);
    end
    for (int i = 0; i < 2; i++) begin
      bit hit = f && (int'(t) == i);
      et[i] = nxt(mt[i], hit, ms[i], c);
      es[i] = c ? 1'b0 : (ms[i] | hit);
      if (hit && c) rt[i] = "R6";
      else if (hit) rt[i] = ms[i] ? "R3" : "R2";
      else if (c) rt[i] = (ms[i]) ? "R5" : "R4";
      else rt[i] = "R10";
    end
    rr = f ? (erf ? "R7" : "R8") : "R9";
    @(negedge clk);
    chk({rt[0], " R11 trust0"}, trust_o[7:0], et[0]);
    chk({rt[1], " R11 trust1"}, trust_o[15:8], et[1]);
    chk({rr, " R11 rollback"}, rollback_o, erb);
    chk({rr, " rollfwd"}, rollfwd_o, erf);
    for (int i = 0; i < 2; i++) begin mt[i] = et[i]; ms[i] = es[i]; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset(3, 20, 10);
    // directed corners
    step(0, 1, 0);                           // R2 first drop, R7 roll-forward
    step(0, 1, 0);                           // R3 halve
    step(0, 1, 0);                           // R8 single rollback
    step(0, 1, 0);                           // R3 clamp at floor
    step(1, 1, 0);                           // R6 fault with checkpoint
    step(1, 0, 0);                           // R4 rise after R6 cleared flag
    step(0, 1, 0);                           // R5/R6 counts as first again
    step(1, 0, 0);                           // R5 faulty interval, no rise
    for (int k = 0; k < 4; k++) step(0, 1, 1); // R11 trailing thread falls
    step(0, 1, 0);                           // R8 both rolled back
    chk("R8 both rollback", rollback_o, 3);
    chk("R8 no rollfwd with both", rollfwd_o, 0);
    step(0, 0, 0);
    for (int k = 0; k < 30; k++) step(1, 0, 0); // R4 saturate at ceiling
    chk("R4 ceiling t0", trust_o[7:0], 20);
    step(0, 0, 0);
    // random phase 1
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) == 0, ($urandom % 10) < 3, $urandom % 2);
    // second configuration, wider range
    do_reset(0, 255, 128);
    for (int k = 0; k < 3000; k++)
      step(($urandom % 3) == 0, ($urandom % 10) < 2, $urandom % 2);
    do_reset(5, 9, 7);
    for (int k = 0; k < 2000; k++)
      step(($urandom % 2) == 0, ($urandom % 10) < 4, $urandom % 2);
    step(0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule